// File: doc/BRIEF.md
# Posted Write Buffer with Deferred Fault Reporting

This block sits between an instruction pipeline and a memory bus. It takes store operations from the pipeline and queues them in a small in-order buffer. The pipeline may retire a store in the same cycle the buffer accepts it, so every architectural update that belongs to the store is final before the memory write has even started. The buffer sends its entries to the bus one at a time through a valid/ready handshake. Each write gets back a single-cycle response that is either ok or error.

A write that ends in an error is reported only after the fact. The block sets a sticky fault flag and raises an access-error request toward the core. The request carries the program counter sampled in the cycle the error response arrives, not the address of the store that failed. The flag stays set until the core acknowledges it. Any further errors that arrive before the acknowledge are absorbed and raise no second request.

A fence request holds off completion until every earlier write has left the buffer and received its response. It then pulses fence-done, and with it the state of the fault flag. A write fault that is still outstanding at the fence is therefore always collected there.

Top module: `post_wbuf`

## Requirements
- R1: After reset, st_ready is 1 and bus_valid, aerr_req, fence_done and fence_err are all 0.
- R2: The buffer holds up to DEPTH (default 4) stores and accepts a store in every cycle in which st_ready is high. st_ready is 0 exactly while DEPTH stores are held or fence_req is high.
- R3: Writes reach the bus in the order they were accepted, with the same address, data and byte enables. Once bus_valid is high it stays high, with those fields unchanged, until the cycle in which bus_ready is high.
- R4: At most one bus write is outstanding. After a handshake, bus_valid stays 0 until the cycle after rsp_valid has been seen.
- R5: A response with rsp_valid=1 and rsp_err=1, received while no fault is pending, sets aerr_req in the next cycle. In that cycle aerr_pc equals the pc_in value present in the cycle of the error response.
- R6: While aerr_req is high, aerr_req and aerr_pc stay unchanged until aerr_ack is sampled high, and further error responses do not alter them. aerr_req goes to 0 in the cycle after the acknowledge, unless an error response arrives in that same cycle.
- R7: fence_done is a one-cycle pulse. It is raised in the cycle after a cycle in which fence_req is high, the buffer is empty and no write is outstanding. It is not raised again until fence_req has been low for a cycle.
- R8: fence_err is high together with fence_done exactly when the fault flag was set in the cycle that met the fence condition. It is 0 at every other time.
- R9: Ok responses (rsp_err=0) never raise aerr_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Pipeline offers a store |
| st_ready | output | 1 | Buffer accepts the offered store this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| pc_in | input | AW | Program counter of the instruction now in flight |
| bus_valid | output | 1 | Head write presented to the bus |
| bus_ready | input | 1 | Bus takes the presented write |
| bus_addr | output | AW | Write address to the bus |
| bus_data | output | DW | Write data to the bus |
| bus_be | output | DW/8 | Write byte enables to the bus |
| rsp_valid | input | 1 | Single-cycle write response |
| rsp_err | input | 1 | Response is an error (valid with rsp_valid) |
| fence_req | input | 1 | Fence pending; held until fence_done |
| fence_done | output | 1 | Fence complete, one-cycle pulse |
| fence_err | output | 1 | Fault flag state reported with fence_done |
| aerr_req | output | 1 | Imprecise access-error request to the core |
| aerr_pc | output | AW | Program counter captured with the fault |
| aerr_ack | input | 1 | Core acknowledges the access-error request |

## Verification
On every cycle the assertions check the properties that can be stated locally. The buffer never accepts a store while full, a stalled bus write holds its fields, no write is presented while one is outstanding, and a fault request holds its captured PC until the acknowledge. They also check that a fence pulse comes only after the buffer has drained and that fence_err never appears without fence_done. What only the bench scenarios can show is end-to-end ordering: each bus write matches the store accepted in that position, and the PC reported with a fault is the one in flight at the error rather than at the store. They also show that a fault left unacknowledged across several fences is reported at each of them, and that absorbed second errors leave the first capture in place.

// File: rtl/post_wbuf_pkg.sv
package post_wbuf_pkg;

   typedef enum logic [0:0] {
      FN_IDLE = 1'b0,
      FN_HELD = 1'b1
   } fence_state_e;

   function automatic int entry_width(input int aw, input int dw);
      return aw + dw + dw / 8;
   endfunction

endpackage

// File: rtl/post_wbuf_fifo.sv
module post_wbuf_fifo #(
   parameter int W     = 68,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] hold_q;
         logic         filled_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filled_q <= 1'b0;
            end else if (push) begin
               filled_q <= 1'b1;
            end else if (pop) begin
               filled_q <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (push) begin
               hold_q <= push_data;
            end
         end

         assign head  = hold_q;
         assign full  = filled_q;
         assign empty = !filled_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
         localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

         logic [W-1:0]  slot_q [DEPTH];
         logic [PW-1:0] wr_ptr_q;
         logic [PW-1:0] rd_ptr_q;
         logic [CW-1:0] count_q;

         function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
            return (p == PTR_LAST) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_ptr_q <= '0;
               rd_ptr_q <= '0;
               count_q  <= '0;
            end else begin
               if (push) begin
                  wr_ptr_q <= step(wr_ptr_q);
               end
               if (pop) begin
                  rd_ptr_q <= step(rd_ptr_q);
               end
               if (push && !pop) begin
                  count_q <= count_q + 1'b1;
               end else if (pop && !push) begin
                  count_q <= count_q - 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (push) begin
               slot_q[wr_ptr_q] <= push_data;
            end
         end

         assign head  = slot_q[rd_ptr_q];
         assign full  = (count_q == CNT_FULL);
         assign empty = (count_q == '0);
      end
   endgenerate

endmodule

// File: rtl/post_wbuf_drain.sv
module post_wbuf_drain (
   input  logic clk,
   input  logic rst_n,
   input  logic empty,
   input  logic bus_ready,
   input  logic rsp_valid,
   output logic bus_valid,
   output logic pop,
   output logic outstanding
);

   logic busy_q;

   assign bus_valid   = !empty && !busy_q;
   assign pop         = bus_valid && bus_ready;
   assign outstanding = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (pop) begin
         busy_q <= 1'b1;
      end else if (rsp_valid) begin
         busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/post_wbuf_fault.sv
module post_wbuf_fault
   import post_wbuf_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rsp_valid,
   input  logic          rsp_err,
   input  logic [AW-1:0] pc_in,
   input  logic          aerr_ack,
   input  logic          drained,
   input  logic          fence_req,
   output logic          aerr_req,
   output logic [AW-1:0] aerr_pc,
   output logic          fence_done,
   output logic          fence_err
);

   logic          sticky_q;
   logic [AW-1:0] pc_q;
   logic          err_in;
   logic          capture;
   fence_state_e  fstate_q;
   logic          done_q;
   logic          ferr_q;

   assign err_in  = rsp_valid && rsp_err;
   assign capture = err_in && (!sticky_q || aerr_ack);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= 1'b0;
         pc_q     <= '0;
      end else begin
         sticky_q <= (sticky_q && !aerr_ack) || err_in;
         if (capture) begin
            pc_q <= pc_in;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fstate_q <= FN_IDLE;
         done_q   <= 1'b0;
         ferr_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         ferr_q <= 1'b0;
         case (fstate_q)
            FN_IDLE: begin
               if (fence_req && drained) begin
                  done_q   <= 1'b1;
                  ferr_q   <= sticky_q;
                  fstate_q <= FN_HELD;
               end
            end
            FN_HELD: begin
               if (!fence_req) begin
                  fstate_q <= FN_IDLE;
               end
            end
            default: fstate_q <= FN_IDLE;
         endcase
      end
   end

   assign aerr_req   = sticky_q;
   assign aerr_pc    = pc_q;
   assign fence_done = done_q;
   assign fence_err  = ferr_q;

endmodule

// File: rtl/post_wbuf.sv
module post_wbuf
   import post_wbuf_pkg::*;
#(
   parameter int AW                 = 32,
   parameter int DW                 = 32,
   parameter int DEPTH              = 4,
   parameter bit FENCE_HOLDS_STORES = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            st_valid,
   output logic            st_ready,
   input  logic [AW-1:0]   st_addr,
   input  logic [DW-1:0]   st_data,
   input  logic [DW/8-1:0] st_be,
   input  logic [AW-1:0]   pc_in,
   output logic            bus_valid,
   input  logic            bus_ready,
   output logic [AW-1:0]   bus_addr,
   output logic [DW-1:0]   bus_data,
   output logic [DW/8-1:0] bus_be,
   input  logic            rsp_valid,
   input  logic            rsp_err,
   input  logic            fence_req,
   output logic            fence_done,
   output logic            fence_err,
   output logic            aerr_req,
   output logic [AW-1:0]   aerr_pc,
   input  logic            aerr_ack
);

   localparam int BW = DW / 8;
   localparam int EW = entry_width(AW, DW);

   generate
      if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
         $error("post_wbuf: DW must be a positive multiple of 8");
      end
      if (AW < 1) begin : g_bad_aw
         $error("post_wbuf: AW must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("post_wbuf: DEPTH must be at least 1");
      end
   endgenerate

   logic          full;
   logic          empty;
   logic          push;
   logic          pop;
   logic          outstanding;
   logic [EW-1:0] head;
   logic          accept_ok;

   generate
      if (FENCE_HOLDS_STORES) begin : g_fence_gate
         assign accept_ok = !full && !fence_req;
      end else begin : g_no_gate
         assign accept_ok = !full;
      end
   endgenerate

   assign st_ready = accept_ok;
   assign push     = st_valid && accept_ok;

   post_wbuf_fifo #(
      .W     (EW),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data ({st_addr, st_data, st_be}),
      .pop       (pop),
      .head      (head),
      .full      (full),
      .empty     (empty)
   );

   assign bus_addr = head[EW-1 -: AW];
   assign bus_data = head[BW +: DW];
   assign bus_be   = head[BW-1:0];

   post_wbuf_drain u_drain (
      .clk         (clk),
      .rst_n       (rst_n),
      .empty       (empty),
      .bus_ready   (bus_ready),
      .rsp_valid   (rsp_valid),
      .bus_valid   (bus_valid),
      .pop         (pop),
      .outstanding (outstanding)
   );

   post_wbuf_fault #(
      .AW (AW)
   ) u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .rsp_valid  (rsp_valid),
      .rsp_err    (rsp_err),
      .pc_in      (pc_in),
      .aerr_ack   (aerr_ack),
      .drained    (empty && !outstanding),
      .fence_req  (fence_req),
      .aerr_req   (aerr_req),
      .aerr_pc    (aerr_pc),
      .fence_done (fence_done),
      .fence_err  (fence_err)
   );

endmodule

// File: rtl/post_wbuf_chk.sv
module post_wbuf_chk #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            st_valid,
   input logic            st_ready,
   input logic [AW-1:0]   pc_in,
   input logic            bus_valid,
   input logic            bus_ready,
   input logic [AW-1:0]   bus_addr,
   input logic [DW-1:0]   bus_data,
   input logic [DW/8-1:0] bus_be,
   input logic            rsp_valid,
   input logic            rsp_err,
   input logic            fence_done,
   input logic            fence_err,
   input logic            aerr_req,
   input logic [AW-1:0]   aerr_pc,
   input logic            aerr_ack
);

   localparam int OW = $clog2(DEPTH + 2);

   logic [OW-1:0] occ;
   logic          inflight;
   logic          acc;
   logic          hs;

   assign acc = st_valid && st_ready;
   assign hs  = bus_valid && bus_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ      <= '0;
         inflight <= 1'b0;
      end else begin
         if (acc && !hs) begin
            occ <= occ + 1'b1;
         end else if (hs && !acc) begin
            occ <= occ - 1'b1;
         end
         if (hs) begin
            inflight <= 1'b1;
         end else if (rsp_valid) begin
            inflight <= 1'b0;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == OW'(DEPTH)) |-> !st_ready); // R2

   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OW'(DEPTH)); // R2

   AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                     && $stable(bus_data) && $stable(bus_be))); // R3

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      inflight |-> !bus_valid); // R4

   AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err && !aerr_req) |=> (aerr_req && aerr_pc == $past(pc_in))); // R5

   AST_STICKY_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (aerr_req && !aerr_ack) |=> (aerr_req && $stable(aerr_pc))); // R6

   AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (aerr_req && aerr_ack && !(rsp_valid && rsp_err)) |=> !aerr_req); // R6

   AST_FENCE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done |-> $past(occ == '0 && !inflight)); // R7

   AST_FENCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done |=> !fence_done); // R7

   AST_FENCE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      fence_err |-> fence_done); // R8

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aerr_req) |-> $past(rsp_valid && rsp_err)); // R9

endmodule

bind post_wbuf post_wbuf_chk #(
   .AW    (AW),
   .DW    (DW),
   .DEPTH (DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .st_valid   (st_valid),
   .st_ready   (st_ready),
   .pc_in      (pc_in),
   .bus_valid  (bus_valid),
   .bus_ready  (bus_ready),
   .bus_addr   (bus_addr),
   .bus_data   (bus_data),
   .bus_be     (bus_be),
   .rsp_valid  (rsp_valid),
   .rsp_err    (rsp_err),
   .fence_done (fence_done),
   .fence_err  (fence_err),
   .aerr_req   (aerr_req),
   .aerr_pc    (aerr_pc),
   .aerr_ack   (aerr_ack)
);

// File: tb/post_wbuf_test.sv
module post_wbuf_test;

   localparam int AW    = 32;
   localparam int DW    = 32;
   localparam int BW    = DW / 8;
   localparam int DEPTH = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            st_valid = 1'b0;
   logic            st_ready;
   logic [AW-1:0]   st_addr = '0;
   logic [DW-1:0]   st_data = '0;
   logic [BW-1:0]   st_be = '0;
   logic [AW-1:0]   pc_in = 32'h0000_1000;
   logic            bus_valid;
   logic            bus_ready = 1'b0;
   logic [AW-1:0]   bus_addr;
   logic [DW-1:0]   bus_data;
   logic [BW-1:0]   bus_be;
   logic            rsp_valid = 1'b0;
   logic            rsp_err = 1'b0;
   logic            fence_req = 1'b0;
   logic            fence_done;
   logic            fence_err;
   logic            aerr_req;
   logic [AW-1:0]   aerr_pc;
   logic            aerr_ack = 1'b0;

   always #2 clk = ~clk;

   always @(posedge clk) pc_in <= pc_in + 32'd4;

   post_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
      .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .pc_in(pc_in),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_be(bus_be), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .fence_req(fence_req), .fence_done(fence_done),
      .fence_err(fence_err), .aerr_req(aerr_req), .aerr_pc(aerr_pc),
      .aerr_ack(aerr_ack)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   typedef struct {
      int          kind;
      logic [31:0] a;
      logic [31:0] d;
      logic [3:0]  be;
      int          n;
   } cmd_t;

   typedef struct {
      logic [31:0] a;
      logic [31:0] d;
      logic [3:0]  be;
   } ent_t;

   localparam int K_STORE = 0;
   localparam int K_FENCE = 1;
   localparam int K_IDLE  = 2;

   cmd_t cq[$];
   ent_t eq[$];

   function automatic bit is_bad(input logic [31:0] d);
      return d[31:28] == 4'hE;
   endfunction

   bit          run = 1'b0;
   bit          out_m = 1'b0;
   int          dly = 0;
   bit          fly_err = 1'b0;
   bit          sticky_m = 1'b0;
   logic [31:0] pc_m = '0;
   bit          fheld = 1'b0;
   bit          cond_p = 1'b0;
   bit          sticky_p = 1'b0;
   bit          p_bus_valid = 1'b0;
   bit          p_st_ready = 1'b1;
   logic [31:0] p_a, p_d, p_pc;
   logic [3:0]  p_be;
   bit          ack_en = 1'b0;
   int          ready_pct = 70;
   int          fence_wait = 0;

   always @(negedge clk) begin
      if (run) begin
         // effects of the edge just passed
         if (st_valid && p_st_ready && cq.size() != 0) begin
            eq.push_back('{a: cq[0].a, d: cq[0].d, be: cq[0].be});
            void'(cq.pop_front());
         end
         if (rsp_valid) out_m = 1'b0;
         if (p_bus_valid && bus_ready) begin
            if (eq.size() == 0) begin
               chk(1'b0, "R3 unexpected bus write", p_a, 0);
            end else begin
               ent_t e;
               e = eq.pop_front();
               chk(p_a == e.a, "R3 order addr", p_a, e.a);
               chk(p_d == e.d && p_be == e.be, "R3 order data", {p_be, p_d}, {e.be, e.d});
               fly_err = is_bad(e.d);
            end
            out_m = 1'b1;
            dly = $urandom_range(0, 3);
         end
         if (rsp_valid && rsp_err && (!sticky_m || aerr_ack)) pc_m = p_pc;
         sticky_m = (sticky_m && !aerr_ack) || (rsp_valid && rsp_err);
         if (fheld && !fence_req) fheld = 1'b0;

         // output checks
         chk(aerr_req == sticky_m, "R5 R6 R9 aerr_req", aerr_req, sticky_m);
         if (sticky_m) chk(aerr_pc == pc_m, "R5 R6 aerr_pc", aerr_pc, pc_m);
         chk(st_ready == (eq.size() < DEPTH && !fence_req), "R2 st_ready", st_ready,
             eq.size() < DEPTH && !fence_req);
         if (out_m) chk(!bus_valid, "R4 bus_valid while outstanding", bus_valid, 0);
         else chk(bus_valid == (eq.size() != 0), "R3 bus_valid", bus_valid, eq.size() != 0);
         if (p_bus_valid && !bus_ready)
            chk(bus_valid && bus_addr == p_a && bus_data == p_d && bus_be == p_be,
                "R3 hold while stalled", bus_addr, p_a);
         chk(fence_done == cond_p, "R7 fence_done", fence_done, cond_p);
         chk(fence_err == (cond_p && sticky_p), "R8 fence_err", fence_err, cond_p && sticky_p);
         if (fence_done) begin
            fheld = 1'b1;
            chk(eq.size() == 0 && !out_m, "R7 drained at fence", eq.size(), 0);
            if (cq.size() != 0 && cq[0].kind == K_FENCE && cq[0].n >= 0)
               chk(fence_err == cq[0].n[0], "R8 directed fence_err", fence_err, cq[0].n[0]);
         end
         p_bus_valid = bus_valid;
         p_st_ready  = st_ready;
         p_a = bus_addr; p_d = bus_data; p_be = bus_be; p_pc = pc_in;

         // next drives
         st_valid = 1'b0;
         if (cq.size() != 0) begin
            case (cq[0].kind)
               K_STORE: begin
                  fence_req = 1'b0;
                  st_valid = 1'b1;
                  st_addr = cq[0].a; st_data = cq[0].d; st_be = cq[0].be;
               end
               K_FENCE: begin
                  if (fence_done) begin
                     void'(cq.pop_front());
                     fence_req = 1'b0;
                     fence_wait = 0;
                  end else begin
                     fence_req = 1'b1;
                     fence_wait++;
                     if (fence_wait > 5000) begin
                        chk(1'b0, "R7 fence never completed", 0, 1);
                        void'(cq.pop_front());
                        fence_req = 1'b0;
                        fence_wait = 0;
                     end
                  end
               end
               default: begin
                  fence_req = 1'b0;
                  if (cq[0].n <= 0) void'(cq.pop_front());
                  else cq[0].n--;
               end
            endcase
         end else begin
            fence_req = 1'b0;
         end
         bus_ready = ($urandom_range(0, 99) < ready_pct);
         rsp_valid = 1'b0;
         rsp_err = 1'b0;
         if (out_m) begin
            if (dly == 0) begin
               rsp_valid = 1'b1;
               rsp_err = fly_err;
            end else begin
               dly--;
            end
         end
         aerr_ack = ack_en && aerr_req && !aerr_ack && ($urandom_range(0, 2) == 0);
         cond_p   = (eq.size() == 0) && !out_m && fence_req && !fheld;
         sticky_p = sticky_m;
      end
   end

   task automatic add_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
      cq.push_back('{kind: K_STORE, a: a, d: d, be: be, n: 0});
   endtask

   task automatic add_fence(input int exp);
      cq.push_back('{kind: K_FENCE, a: 0, d: 0, be: 0, n: exp});
   endtask

   task automatic drain_cmds();
      while (cq.size() != 0) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd20240611);
      repeat (3) @(negedge clk);
      chk(st_ready == 1'b1, "R1 reset st_ready", st_ready, 1);
      chk(bus_valid == 1'b0, "R1 reset bus_valid", bus_valid, 0);
      chk(aerr_req == 1'b0, "R1 reset aerr_req", aerr_req, 0);
      chk(fence_done == 1'b0 && fence_err == 1'b0, "R1 reset fence", {fence_done, fence_err}, 0);
      rst_n = 1'b1;
      p_pc = pc_in;
      run = 1'b1;

      // R2: fill with the bus stalled
      ready_pct = 0;
      for (int i = 0; i < DEPTH + 1; i++)
         add_store(32'h100 + 32'(i * 4), 32'h1111_0000 + 32'(i), 4'hF);
      repeat (20) @(negedge clk);
      chk(st_ready == 1'b0, "R2 full buffer stalls store", st_ready, 0);
      chk(cq.size() == 1, "R2 four stores taken", cq.size(), 1);
      ready_pct = 80;
      drain_cmds();
      add_fence(0);
      drain_cmds();
      chk(aerr_req == 1'b0, "R9 ok writes raise nothing", aerr_req, 0);

      // R5 R8: error write with no acknowledge, collected at fences
      add_store(32'h200, 32'h2222_0001, 4'h3);
      add_store(32'h204, 32'hE000_0BAD, 4'hC);
      add_store(32'h208, 32'h2222_0003, 4'hF);
      add_fence(1);
      drain_cmds();
      chk(aerr_req == 1'b1, "R6 fault still pending", aerr_req, 1);
      add_store(32'h20C, 32'hE000_0002, 4'hF);
      add_fence(1);
      drain_cmds();

      // R6: acknowledge, then a clean fence and a fence on an empty buffer
      ack_en = 1'b1;
      while (aerr_req) @(negedge clk);
      add_fence(0);
      add_idle_then_fence();
      drain_cmds();

      // random phase
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (i % 100 == 0) ready_pct = $urandom_range(20, 100);
         if (r < 70) begin
            logic [31:0] d;
            d = $urandom();
            if (d[31:28] == 4'hE && $urandom_range(0, 1) == 0) d[31] = 1'b0;
            add_store($urandom() & 32'hFFFF_FFFC, d, 4'($urandom_range(1, 15)));
         end else if (r < 80) begin
            add_fence(-1);
         end else begin
            cq.push_back('{kind: K_IDLE, a: 0, d: 0, be: 0, n: $urandom_range(0, 5)});
         end
      end
      add_fence(-1);
      drain_cmds();
      repeat (5) @(negedge clk);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic add_idle_then_fence();
      cq.push_back('{kind: K_IDLE, a: 0, d: 0, be: 0, n: 3});
      add_fence(0);
   endtask

endmodule